// File: doc/BRIEF.md
# Double-Rate Input Deserializer with Selectable Gearing

This block turns one high-speed serial input into parallel words for the core. Serial data is sampled on both edges of a fast edge clock. It is packed into words whose length depends on the mode selected, and the words are handed to a slower system clock through a small gray-pointer crossing buffer. A holding register in the slow domain presents each word together with a one-cycle valid strobe.

There are three gearings. The 7-bit mode is for video-style links, with the fast clock at 3.5 times the slow clock. The 8-bit mode runs the fast clock at 4 times the slow clock. In the split mode, two independent 4-bit gearboxes each receive their own serial input, with the fast clock at twice the slow clock. The core can move the word boundary at run time. Each one-cycle pulse on the slip input discards one incoming bit, so every later word starts one bit further along the stream.

The mode is static and may only change while reset is held.

Top module: `gbx_deser_top`

## Requirements
- R1: `mode` selects the word length: 0 gives 7-bit words, 2 gives the split 4+4 mode, and 1 or 3 give 8-bit words. Each delivered word holds exactly that many consecutive stream bits.
- R2: `din_a` is sampled on every falling edge and every rising edge of `eclk`. A bit taken on a falling edge comes before the bit taken on the next rising edge. The earliest bit of a word lands in `dout[0]` (in the split mode, in bit 0 of its lane).
- R3: In 7-bit mode the word sits on `dout[6:0]` and `dout[7]` always reads 0.
- R4: In the split mode, the `din_a` gearbox drives `dout[7:4]` with its earliest bit at `dout[4]`, and the `din_b` gearbox drives `dout[3:0]` with its earliest bit at `dout[0]`.
- R5: Every assembled word is delivered exactly once and in order. It appears on `dout` together with a one-`sclk`-cycle pulse on `dvld`.
- R6: While `rst` is high, and until the first complete word has crossed over, `dout` reads zero and `dvld` stays low.
- R7: After reset, the first word begins with the bit sampled on the first falling edge of `eclk` that follows the last rising edge at which `rst` was seen high.
- R8: Each `slip` pulse, one `sclk` cycle wide, drops exactly one incoming bit. Afterwards every word starts one bit later in the stream, and repeated pulses add up.
- R9: In the split mode, a `slip` pulse shifts both 4-bit gearboxes by one bit each.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| eclk | input | 1 | Fast edge clock; data sampled on both edges |
| sclk | input | 1 | Slow system clock for the parallel side |
| rst | input | 1 | Synchronous active-high reset, seen by both clocks |
| mode | input | 2 | Gearing select (0: 7-bit, 1/3: 8-bit, 2: split 4+4) |
| din_a | input | 1 | Serial input of the main gearbox |
| din_b | input | 1 | Serial input of the second gearbox (split mode only) |
| slip | input | 1 | Word-boundary slip request, `sclk` domain |
| dout | output | 8 | Parallel word in the `sclk` domain |
| dvld | output | 1 | One-cycle strobe marking a new word on `dout` |

## Verification
A wrong fill count or a bad merge of the falling and rising samples shows up as a misaligned or bit-swapped word on the first delivery after reset. That happens within about three slow cycles, so the random-stream scoreboard catches it at once. A lost or duplicated word in the crossing buffer leaves every later word out of step with the expected queue. A slip that drops no bit, or more than one, is exposed with periodic patterns: the settled output must be the pattern rotated by exactly the number of pulses, within a dozen slow cycles.

// File: rtl/gbx_pkg.sv
`timescale 1ns/1ps
package gbx_pkg;

    localparam int GB_WORD_W = 8;

    typedef enum logic [1:0] {
        MODE_X7    = 2'd0,
        MODE_X8    = 2'd1,
        MODE_DUAL4 = 2'd2,
        MODE_X8ALT = 2'd3
    } gb_mode_e;

    function automatic int word_len(input gb_mode_e m);
        case (m)
            MODE_X7:    return 7;
            MODE_DUAL4: return GB_WORD_W / 2;
            default:    return GB_WORD_W;
        endcase
    endfunction

    function automatic logic [7:0] bin_to_gray(input logic [7:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [7:0] gray_to_bin(input logic [7:0] g);
        logic [7:0] b;
        b[7] = g[7];
        for (int i = 6; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/gbx_sync.sv
`timescale 1ns/1ps
module gbx_sync #(
    parameter int STAGES = 2,
    parameter int W      = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stage_q[s] <= '0;
                else     stage_q[s] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stage_q[s] <= '0;
                else     stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gbx_lane.sv
`timescale 1ns/1ps
module gbx_lane #(
    parameter int W  = 8,
    parameter int CW = $clog2(W + 2)
) (
    input  logic          eclk,
    input  logic          rst,
    input  logic          din,
    input  logic          slip,
    input  logic [CW-1:0] wlen,
    output logic [W-1:0]  word,
    output logic          wvalid
);
    localparam int AW = W + 2;

    logic          fall_q;
    logic [AW-1:0] acc_q, ext, rem;
    logic [CW-1:0] cnt_q, tot;
    logic [W-1:0]  word_nx;

    // falling-edge sample; it is merged at the next rising edge
    always_ff @(negedge eclk) begin
        if (rst) fall_q <= 1'b0;
        else     fall_q <= din;
    end

    always_comb begin
        ext = acc_q;
        for (int i = 0; i < AW; i++) begin
            if (CW'(i) == cnt_q) ext[i] = slip ? din : fall_q;
            if (!slip && (CW'(i) == cnt_q + CW'(1))) ext[i] = din;
        end
        tot = slip ? cnt_q + CW'(1) : cnt_q + CW'(2);
        for (int i = 0; i < W; i++) begin
            word_nx[i] = (CW'(i) < wlen) ? ext[i] : 1'b0;
        end
        rem = ext >> wlen;
    end

    always_ff @(posedge eclk) begin
        if (rst) begin
            acc_q  <= '0;
            cnt_q  <= '0;
            word   <= '0;
            wvalid <= 1'b0;
        end else if (tot >= wlen) begin
            word   <= word_nx;
            wvalid <= 1'b1;
            acc_q  <= rem;
            cnt_q  <= tot - wlen;
        end else begin
            acc_q  <= ext;
            cnt_q  <= tot;
            wvalid <= 1'b0;
        end
    end

    // R1
    fill_bound_chk: assert property (@(posedge eclk) disable iff (rst)
        cnt_q < wlen);

    // R5
    word_gap_chk: assert property (@(posedge eclk) disable iff (rst)
        wvalid |=> !wvalid);
endmodule

// File: rtl/gbx_xfer.sv
`timescale 1ns/1ps
module gbx_xfer import gbx_pkg::*; #(
    parameter int W      = 8,
    parameter int AW     = 3,
    parameter int STAGES = 2
) (
    input  logic         wclk,
    input  logic         rclk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] rdata,
    output logic         rvld
);
    localparam int DEPTH = 1 << AW;
    localparam int PW    = AW + 1;

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wbin_q, wgray_q, rbin_q, rgray_q;
    logic [PW-1:0] wbin_nx, rbin_nx, rgray_w, wgray_r, rbin_w;
    logic          full, empty;

    assign wbin_nx = wbin_q + PW'(1);
    assign rbin_nx = rbin_q + PW'(1);

    gbx_sync #(.STAGES(STAGES), .W(PW)) u_rd_to_wr (
        .clk(wclk), .rst(rst), .d(rgray_q), .q(rgray_w));
    gbx_sync #(.STAGES(STAGES), .W(PW)) u_wr_to_rd (
        .clk(rclk), .rst(rst), .d(wgray_q), .q(wgray_r));

    assign rbin_w = PW'(gray_to_bin(8'(rgray_w)));
    assign full   = (wbin_q - rbin_w) == PW'(DEPTH);
    assign empty  = (rgray_q == wgray_r);

    always_ff @(posedge wclk) begin
        if (rst) begin
            wbin_q  <= '0;
            wgray_q <= '0;
        end else if (wr_en) begin
            wbin_q  <= wbin_nx;
            wgray_q <= PW'(bin_to_gray(8'(wbin_nx)));
        end
    end

    always_ff @(posedge wclk) begin
        if (wr_en) mem[wbin_q[AW-1:0]] <= wdata;
    end

    always_ff @(posedge rclk) begin
        if (rst) begin
            rbin_q  <= '0;
            rgray_q <= '0;
            rdata   <= '0;
            rvld    <= 1'b0;
        end else if (!empty) begin
            rdata   <= mem[rbin_q[AW-1:0]];
            rvld    <= 1'b1;
            rbin_q  <= rbin_nx;
            rgray_q <= PW'(bin_to_gray(8'(rbin_nx)));
        end else begin
            rvld    <= 1'b0;
        end
    end

    // R5
    no_overflow_chk: assert property (@(posedge wclk) disable iff (rst)
        wr_en |-> !full);
endmodule

// File: rtl/gbx_deser_top.sv
`timescale 1ns/1ps
module gbx_deser_top import gbx_pkg::*; #(
    parameter int FIFO_AW     = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic       eclk,
    input  logic       sclk,
    input  logic       rst,
    input  logic [1:0] mode,
    input  logic       din_a,
    input  logic       din_b,
    input  logic       slip,
    output logic [7:0] dout,
    output logic       dvld
);
    localparam int WORD_W = GB_WORD_W;
    localparam int HALF_W = WORD_W / 2;
    localparam int NLANE  = 2;
    localparam int CWA    = $clog2(WORD_W + 2);
    localparam int CWB    = $clog2(HALF_W + 2);

    gb_mode_e          mode_e;
    logic [CWA-1:0]    wlen_a;
    logic [NLANE-1:0]  ser;
    logic [WORD_W-1:0] word_a, wdata;
    logic [HALF_W-1:0] word_b;
    logic              vld_a, vld_b, wr_en;
    logic              slip_tog_q, slip_seen_q, slip_f;
    logic [0:0]        slip_tog_s;

    assign mode_e = gb_mode_e'(mode);
    assign wlen_a = CWA'(word_len(mode_e));
    assign ser    = {din_b, din_a};

    // slip request: toggle in the slow domain, edge detect in the fast domain
    always_ff @(posedge sclk) begin
        if (rst)       slip_tog_q <= 1'b0;
        else if (slip) slip_tog_q <= ~slip_tog_q;
    end

    gbx_sync #(.STAGES(SYNC_STAGES), .W(1)) u_slip_sync (
        .clk(eclk), .rst(rst), .d(slip_tog_q), .q(slip_tog_s));

    always_ff @(posedge eclk) begin
        if (rst) slip_seen_q <= 1'b0;
        else     slip_seen_q <= slip_tog_s[0];
    end
    assign slip_f = slip_tog_s[0] ^ slip_seen_q;

    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        if (g == 0) begin : g_full
            gbx_lane #(.W(WORD_W)) u_lane (
                .eclk(eclk), .rst(rst), .din(ser[g]), .slip(slip_f),
                .wlen(wlen_a), .word(word_a), .wvalid(vld_a));
        end else begin : g_half
            gbx_lane #(.W(HALF_W)) u_lane (
                .eclk(eclk), .rst(rst), .din(ser[g]), .slip(slip_f),
                .wlen(CWB'(HALF_W)), .word(word_b), .wvalid(vld_b));
        end
    end

    // fixed lane mapping: main lane on the upper nibble in split mode
    always_comb begin
        if (mode_e == MODE_DUAL4) begin
            wr_en = vld_a & vld_b;
            wdata = {word_a[HALF_W-1:0], word_b};
        end else begin
            wr_en = vld_a;
            wdata = word_a;
        end
    end

    gbx_xfer #(.W(WORD_W), .AW(FIFO_AW), .STAGES(SYNC_STAGES)) u_xfer (
        .wclk(eclk), .rclk(sclk), .rst(rst), .wr_en(wr_en), .wdata(wdata),
        .rdata(dout), .rvld(dvld));

    // R3
    top_bit_chk: assert property (@(posedge sclk) disable iff (rst)
        (mode_e == MODE_X7 && dvld) |-> !dout[7]);

    // R6
    reset_clear_chk: assert property (@(posedge sclk)
        rst |=> (dout == '0 && !dvld));
endmodule

// File: tb/gbx_deser_top_tb_top.sv
`timescale 1ns/1ps
module gbx_deser_top_tb_top;
    logic       eclk = 1'b0;
    logic       sclk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] mode = 2'd0;
    logic       din_a = 1'b0;
    logic       din_b = 1'b0;
    logic       slip = 1'b0;
    logic [7:0] dout;
    logic       dvld;

    real shalf = 17.5;
    int  n_chk = 0;
    int  n_bad = 0;
    bit  sb_on = 1'b0;
    bit  stop_drv = 1'b0;
    int  word_idx = 0;
    string cur_req = "R1";

    logic [7:0] exp_q [$];
    logic       abits [0:1023];
    logic       bbits [0:1023];

    gbx_deser_top dut_i (
        .eclk(eclk), .sclk(sclk), .rst(rst), .mode(mode), .din_a(din_a),
        .din_b(din_b), .slip(slip), .dout(dout), .dvld(dvld));

    initial forever #5 eclk = ~eclk;
    initial begin
        #1;
        forever #(shalf) sclk = ~sclk;
    end

    task automatic check(input bit ok, input string req,
                         input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FIL%s %s actual=%h expected=%h", "", req, act, exp);
        end
    endtask

    // scoreboard monitor
    always @(negedge sclk) begin
        if (sb_on && !rst && dvld && exp_q.size() > 0) begin
            logic [7:0] e;
            e = exp_q.pop_front();
            check(dout === e, (word_idx == 0) ? "R7 first word" : cur_req, dout, e);
            word_idx++;
        end
    end

    task automatic open_run(input logic [1:0] m, input real sh);
        rst = 1'b1; mode = m; shalf = sh; slip = 1'b0;
        din_a = 1'b0; din_b = 1'b0;
        repeat (8) @(posedge sclk);
        @(negedge sclk);
        check(dout === 8'h00 && dvld === 1'b0, "R6 reset state", dout, 8'h00);
        @(posedge eclk);
        #2.5;
        rst = 1'b0;
    endtask

    task automatic run_random(input logic [1:0] m, input real sh,
                              input int nw, input string req);
        int wl;
        int nb;
        wl = (m == 2'd0) ? 7 : (m == 2'd2) ? 4 : 8;
        exp_q.delete();
        for (int w = 0; w < nw; w++) begin
            logic [7:0] r;
            r = 8'($urandom);
            if (m == 2'd0) r[7] = 1'b0;
            for (int b = 0; b < wl; b++) begin
                if (m == 2'd2) begin
                    abits[w*wl+b] = r[4+b];
                    bbits[w*wl+b] = r[b];
                end else begin
                    abits[w*wl+b] = r[b];
                    bbits[w*wl+b] = 1'b0;
                end
            end
            exp_q.push_back(r);
        end
        nb = nw * wl;
        cur_req = req;
        word_idx = 0;
        sb_on = 1'b1;
        open_run(m, sh);
        for (int k = 0; k < nb; k++) begin
            din_a = abits[k];
            din_b = bbits[k];
            #5;
        end
        din_a = 1'b0; din_b = 1'b0;
        repeat (12) @(posedge sclk);
        @(negedge sclk);
        check(exp_q.size() == 0, "R5 all words delivered",
              8'(exp_q.size()), 8'h00);
        sb_on = 1'b0;
    endtask

    function automatic logic [7:0] rot(input logic [7:0] p, input int wl, input int k);
        logic [7:0] r;
        r = 8'h00;
        for (int j = 0; j < wl; j++) r[j] = p[(j + k) % wl];
        return r;
    endfunction

    function automatic logic [7:0] slip_exp(input logic [1:0] m, input logic [7:0] pa,
                                            input logic [7:0] pb, input int k);
        if (m == 2'd2) return {rot(pa, 4, k)[3:0], rot(pb, 4, k)[3:0]};
        return rot(pa, (m == 2'd0) ? 7 : 8, k);
    endfunction

    task automatic next_word;
        do @(negedge sclk); while (!dvld);
    endtask

    task automatic slip_pulse;
        @(negedge sclk); slip = 1'b1;
        @(negedge sclk); slip = 1'b0;
        repeat (3) @(negedge sclk);
    endtask

    task automatic run_slip(input logic [1:0] m, input real sh, input logic [7:0] pa,
                            input logic [7:0] pb, input string req);
        int wl;
        wl = (m == 2'd0) ? 7 : (m == 2'd2) ? 4 : 8;
        stop_drv = 1'b0;
        open_run(m, sh);
        fork
            begin
                int k;
                k = 0;
                while (!stop_drv) begin
                    din_a = pa[k % wl];
                    din_b = pb[k % wl];
                    #5;
                    k++;
                end
            end
        join_none
        repeat (20) @(negedge sclk);
        next_word;
        check(dout === slip_exp(m, pa, pb, 0), {req, " before slip"}, dout, slip_exp(m, pa, pb, 0));
        slip_pulse;
        repeat (12) @(negedge sclk);
        for (int i = 0; i < 3; i++) begin
            next_word;
            check(dout === slip_exp(m, pa, pb, 1), {req, " one slip"}, dout, slip_exp(m, pa, pb, 1));
        end
        slip_pulse;
        slip_pulse;
        repeat (12) @(negedge sclk);
        for (int i = 0; i < 3; i++) begin
            next_word;
            check(dout === slip_exp(m, pa, pb, 3), {req, " three slips"}, dout, slip_exp(m, pa, pb, 3));
        end
        stop_drv = 1'b1;
        #20;
    endtask

    initial begin
        // R1 R2 R3 R7: 7-bit gearing, random stream
        run_random(2'd0, 17.5, 60, "R3 7-bit word");
        // R1 R2: 8-bit gearing
        run_random(2'd1, 20.0, 60, "R2 8-bit word");
        // R1: encoding 3 behaves as 8-bit
        run_random(2'd3, 20.0, 30, "R1 mode 3 word");
        // R4: split mode lane mapping
        run_random(2'd2, 10.0, 60, "R4 split word");
        // R8: slip in 7-bit and 8-bit gearing
        run_slip(2'd0, 17.5, 8'b0001_0011, 8'h00, "R8 7-bit");
        run_slip(2'd1, 20.0, 8'b0001_0111, 8'h00, "R8 8-bit");
        // R9: slip moves both split lanes
        run_slip(2'd2, 10.0, 8'b0000_0001, 8'b0000_0011, "R9 split");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #1500000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule